// File: doc/BRIEF.md
# Chunked Hamming Parity Generator for a NAND Byte Stream

This block watches the bytes that cross a NAND flash data interface and builds single-error-correcting Hamming parity over each consecutive 256-byte chunk. For every accepted byte it updates a set of paired parity bits. One set of pairs is selected by the position of the byte within the chunk (line parity). The other set is selected by the position of each bit within the byte (column parity).

When the last byte of a chunk is accepted, the finished parity is loaded into a readable 32-bit result register. A one-cycle completion pulse is raised, and accumulation starts again from zero for the next chunk. Software or a DMA engine reads the register at each chunk boundary.

A combinational conversion also presents the 24-bit form that is stored in the flash spare area. That form is the result shifted left by two, inverted, and cut to 24 bits. A clear input restarts the whole computation, and an enable input selects whether bytes on the interface take part at all.

Top module: `eccgen_top`

## Requirements
- R1: A byte is accepted only on a clock edge where byteValid and eccEn are both 1 and eccClear is 0. A byte presented while eccEn is 0 changes neither the parity nor the position within the chunk.
- R2: A chunk is 256 accepted bytes, indexed 0 to 255 in order of acceptance. On the edge that accepts byte 255, eccReg loads the parity of the whole chunk, the accumulator and index restart from zero, and chunkDone is 1 for exactly the following cycle.
- R3: Column parity occupies eccReg[5:0]. Line parity occupies eccReg[21:6]. eccReg[31:22] is always 0.
- R4: For j in 0..2, eccReg[2j] is the XOR of every data bit of the chunk whose bit position b within its byte has bit j of b equal to 0. eccReg[2j+1] is the same XOR over positions where bit j of b is 1.
- R5: For k in 0..7, eccReg[6+2k] is the XOR of all bits of every byte whose chunk index has bit k equal to 0. eccReg[7+2k] is the same XOR over bytes whose index has bit k equal to 1.
- R6: storedCode equals the inverse of (eccReg shifted left by 2), keeping bits 23:0, so storedCode[1:0] is always 2'b11. storedCode[23:16] is the first byte written to the spare area.
- R7: eccClear set to 1 at an edge zeroes the accumulator, the chunk index and eccReg, and lowers chunkDone. It has priority over a byte presented in the same cycle, and that byte is dropped.
- R8: eccReg keeps its value between chunk completions and clears, whatever bytes are accepted in between.
- R9: After reset, eccReg is 0, chunkDone is 0 and storedCode is 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eccEn | input | 1 | Parity accumulation enable |
| eccClear | input | 1 | Restart accumulation and zero the result |
| byteValid | input | 1 | A byte is on byteData this cycle |
| byteData | input | 8 | Byte crossing the flash interface |
| eccReg | output | 32 | Result of the last completed chunk: column parity [5:0], line parity [21:6] |
| storedCode | output | 24 | Spare-area form of eccReg, first byte in [23:16] |
| chunkDone | output | 1 | One-cycle pulse after a chunk completes |

## Verification
The bench aims at four failure modes.

- A single flipped bit at byte 37, bit 5 must produce one exact result word. An accumulator that confuses odd and even members of a pair, or that packs the line and column fields at the wrong offsets, gives a different word there.
- Bytes presented while accumulation is disabled are mixed into a chunk. A design that counts them would finish the chunk early and raise chunkDone too soon.
- A clear arrives in the same cycle as a valid byte. If the byte is kept, the chunk ends one byte early.
- Bytes that arrive after a chunk completes are checked against the latched result. A design that shows the live accumulator would let that result drift.

An all-ones chunk also checks that parity contributions cancel, and a full reference model compares every output on every clock.

// File: rtl/eccgen_pkg.sv
package eccgen_pkg;
  // Strobes from the chunk control to the parity datapath.
  typedef struct packed {
    logic clear;     // restart everything
    logic accept;    // a byte takes part this cycle
    logic lastByte;  // accepted byte closes the chunk
  } eccStrobes_t;
endpackage

// File: rtl/eccgen_ctrl.sv
module eccgen_ctrl
  import eccgen_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 256,
  parameter int unsigned IDX_W = $clog2(CHUNK_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eccEn,
  input  logic             eccClear,
  input  logic             byteValid,
  output eccStrobes_t      strobes,
  output logic [IDX_W-1:0] byteIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNK_BYTES - 1);

  logic [IDX_W-1:0] idxQ;

  always_comb begin
    strobes.clear    = eccClear;
    strobes.accept   = byteValid & eccEn & ~eccClear;
    strobes.lastByte = strobes.accept & (idxQ == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strobes.clear) begin
      idxQ <= '0;
    end else if (strobes.accept) begin
      idxQ <= strobes.lastByte ? '0 : idxQ + 1'b1;
    end
  end

  assign byteIdx = idxQ;
endmodule

// File: rtl/eccgen_datapath.sv
module eccgen_datapath
  import eccgen_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned REG_W = 32,
  parameter int unsigned STORED_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  eccStrobes_t         strobes,
  input  logic [IDX_W-1:0]    byteIdx,
  input  logic [DATA_W-1:0]   byteData,
  output logic [REG_W-1:0]    eccReg,
  output logic [STORED_W-1:0] storedCode,
  output logic                chunkDone
);
  localparam int unsigned BIT_IDX_W = $clog2(DATA_W);
  localparam int unsigned COL_W = 2 * BIT_IDX_W;
  localparam int unsigned LINE_W = 2 * IDX_W;
  localparam int unsigned PAR_W = COL_W + LINE_W;

  logic [COL_W-1:0]  colContrib;
  logic [LINE_W-1:0] lineContrib;
  logic [PAR_W-1:0]  accQ;
  logic [PAR_W-1:0]  accNext;
  logic              bytePar;

  assign bytePar = ^byteData;

  // Line pairs: byte parity steered by each bit of the chunk index.
  for (genvar gk = 0; gk < IDX_W; gk++) begin : g_line
    assign lineContrib[2*gk]   = bytePar & ~byteIdx[gk];
    assign lineContrib[2*gk+1] = bytePar &  byteIdx[gk];
  end

  // Column pairs: data bits split by each bit of their position in the byte.
  for (genvar gj = 0; gj < BIT_IDX_W; gj++) begin : g_col
    logic evenSum;
    logic oddSum;
    always_comb begin
      evenSum = 1'b0;
      oddSum  = 1'b0;
      for (int b = 0; b < DATA_W; b++) begin
        if (((b >> gj) & 1) != 0) oddSum = oddSum ^ byteData[b];
        else                      evenSum = evenSum ^ byteData[b];
      end
    end
    assign colContrib[2*gj]   = evenSum;
    assign colContrib[2*gj+1] = oddSum;
  end

  assign accNext = accQ ^ {lineContrib, colContrib};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      eccReg    <= '0;
      chunkDone <= 1'b0;
    end else if (strobes.clear) begin
      accQ      <= '0;
      eccReg    <= '0;
      chunkDone <= 1'b0;
    end else if (strobes.lastByte) begin
      accQ      <= '0;
      eccReg    <= REG_W'(accNext);
      chunkDone <= 1'b1;
    end else begin
      if (strobes.accept) accQ <= accNext;
      chunkDone <= 1'b0;
    end
  end

  // Spare-area form: shift left two, invert, keep the low STORED_W bits.
  assign storedCode = ~{eccReg[STORED_W-3:0], 2'b00};
endmodule

// File: rtl/eccgen_top.sv
module eccgen_top
  import eccgen_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 256,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_W = 32,
  parameter int unsigned STORED_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                eccEn,
  input  logic                eccClear,
  input  logic                byteValid,
  input  logic [DATA_W-1:0]   byteData,
  output logic [REG_W-1:0]    eccReg,
  output logic [STORED_W-1:0] storedCode,
  output logic                chunkDone
);
  localparam int unsigned IDX_W = $clog2(CHUNK_BYTES);

  eccStrobes_t      strobes;
  logic [IDX_W-1:0] byteIdx;

  eccgen_ctrl #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .IDX_W(IDX_W)
  ) i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .eccEn(eccEn),
    .eccClear(eccClear),
    .byteValid(byteValid),
    .strobes(strobes),
    .byteIdx(byteIdx)
  );

  eccgen_datapath #(
    .DATA_W(DATA_W),
    .IDX_W(IDX_W),
    .REG_W(REG_W),
    .STORED_W(STORED_W)
  ) i_datapath (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .byteIdx(byteIdx),
    .byteData(byteData),
    .eccReg(eccReg),
    .storedCode(storedCode),
    .chunkDone(chunkDone)
  );
endmodule

// File: rtl/eccgen_checker.sv
module eccgen_checker (
  input logic        clk,
  input logic        rstN,
  input logic        eccEn,
  input logic        eccClear,
  input logic        byteValid,
  input logic [31:0] eccReg,
  input logic [23:0] storedCode,
  input logic        chunkDone
);
  logic pairPar;
  assign pairPar = eccReg[0] ^ eccReg[1];

  // R7: a clear empties the result and suppresses completion
  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    eccClear |=> (eccReg == 32'd0) && !chunkDone);

  // R1: completion only follows an accepted byte
  a_r1_done_needs_accept: assert property (@(posedge clk) disable iff (!rstN)
    chunkDone |-> $past(byteValid && eccEn && !eccClear));

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    chunkDone |=> !chunkDone);

  // R8: without an accepted byte or a clear the result holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!eccClear && !(byteValid && eccEn)) |=> $stable(eccReg));

  // R3: unused upper bits stay zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    eccReg[31:22] == 10'd0);

  // R4 / R5: every pair sums to the same overall chunk parity
  a_r4_pair_consistency: assert property (@(posedge clk) disable iff (!rstN)
    ((eccReg[2] ^ eccReg[3]) == pairPar) && ((eccReg[4] ^ eccReg[5]) == pairPar)
    && ((eccReg[6] ^ eccReg[7]) == pairPar) && ((eccReg[20] ^ eccReg[21]) == pairPar));

  // R6: the two padding bits of the stored form are always set
  a_r6_stored_pad: assert property (@(posedge clk) disable iff (!rstN)
    storedCode[1:0] == 2'b11);
endmodule

bind eccgen_top eccgen_checker i_checker (
  .clk(clk),
  .rstN(rstN),
  .eccEn(eccEn),
  .eccClear(eccClear),
  .byteValid(byteValid),
  .eccReg(eccReg),
  .storedCode(storedCode),
  .chunkDone(chunkDone)
);

// File: tb/test_eccgen_top.sv
`timescale 1ns/1ps
module test_eccgen_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eccEn = 1'b0;
  logic        eccClear = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'd0;
  logic [31:0] eccReg;
  logic [23:0] storedCode;
  logic        chunkDone;

  int nChecks = 0;
  int nFail = 0;
  string curReq = "R9";

  always #2 clk = ~clk;  // 250 MHz

  eccgen_top i_eccgen_top (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .eccClear(eccClear),
    .byteValid(byteValid), .byteData(byteData),
    .eccReg(eccReg), .storedCode(storedCode), .chunkDone(chunkDone)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int          refCnt = 0;
  logic [31:0] refAcc = '0;
  logic [31:0] refReg = '0;
  logic        refDone = 1'b0;

  always @(posedge clk) begin
    if (!rstN || eccClear) begin
      refCnt = 0; refAcc = '0; refReg = '0; refDone = 1'b0;
    end else if (byteValid && eccEn) begin
      for (int b = 0; b < 8; b++) begin
        if (byteData[b]) begin
          for (int j = 0; j < 3; j++) refAcc[2*j + ((b >> j) & 1)] ^= 1'b1;
          for (int k = 0; k < 8; k++) refAcc[6 + 2*k + ((refCnt >> k) & 1)] ^= 1'b1;
        end
      end
      refCnt++;
      if (refCnt == 256) begin
        refReg = refAcc; refAcc = '0; refCnt = 0; refDone = 1'b1;
      end else refDone = 1'b0;
    end else refDone = 1'b0;
  end

  function automatic logic [31:0] storedOf(logic [31:0] r);
    return (~(r << 2)) & 32'h00FF_FFFF;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      chk({curReq, " model eccReg"}, eccReg, refReg);
      chk("R6 model storedCode", {8'd0, storedCode}, storedOf(refReg));
      chk({curReq, " model chunkDone"}, {31'd0, chunkDone}, {31'd0, refDone});
    end
  end

  task automatic step(logic v, logic en, logic clr, logic [7:0] d);
    byteValid = v; eccEn = en; eccClear = clr; byteData = d;
    @(posedge clk); #1;
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [7:0] nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : stim
    logic [31:0] saved;
    int sent;
    repeat (3) step(0, 0, 0, 8'd0);
    // R9 reset state
    chk("R9 eccReg", eccReg, 32'd0);
    chk("R9 chunkDone", {31'd0, chunkDone}, 32'd0);
    chk("R9 storedCode", {8'd0, storedCode}, 32'h00FF_FFFF);
    rstN = 1'b1;
    step(0, 1, 0, 8'd0);

    // Single bit at byte 37, bit 5
    curReq = "R5";
    for (int i = 0; i < 256; i++) step(1, 1, 0, (i == 37) ? 8'h20 : 8'h00);
    chk("R2 done after last byte", {31'd0, chunkDone}, 32'd1);
    chk("R5 single-bit word", eccReg, 32'h0016_59A6);
    chk("R4 column field", {26'd0, eccReg[5:0]}, 32'h26);
    chk("R3 upper bits zero", {22'd0, eccReg[31:22]}, 32'd0);
    chk("R6 stored single-bit", {8'd0, storedCode}, 32'h00A6_9967);
    step(0, 1, 0, 8'd0);
    chk("R2 done is one cycle", {31'd0, chunkDone}, 32'd0);

    // R1: disabled bytes and gaps mixed into a chunk
    curReq = "R1";
    sent = 0;
    for (int i = 0; sent < 256; i++) begin
      if (i % 5 == 4) step(1, 0, 0, nextRand());
      else if (i % 7 == 3) step(0, 1, 0, nextRand());
      else begin step(1, 1, 0, nextRand()); sent++; end
      if (sent < 256) chk("R1 no early done", {31'd0, chunkDone}, 32'd0);
    end
    chk("R1 done on 256th enabled byte", {31'd0, chunkDone}, 32'd1);

    // R8: result holds while the next chunk accumulates
    curReq = "R8";
    saved = eccReg;
    for (int i = 0; i < 100; i++) step(1, 1, 0, nextRand());
    chk("R8 held result", eccReg, saved);

    // R7: clear with a byte in the same cycle drops that byte
    curReq = "R7";
    step(1, 1, 1, 8'hFF);
    chk("R7 cleared eccReg", eccReg, 32'd0);
    chk("R7 cleared storedCode", {8'd0, storedCode}, 32'h00FF_FFFF);
    for (int i = 0; i < 255; i++) step(1, 1, 0, nextRand());
    chk("R7 not done after 255", {31'd0, chunkDone}, 32'd0);
    step(1, 1, 0, nextRand());
    chk("R7 done after 256", {31'd0, chunkDone}, 32'd1);

    // R4: all-ones chunk cancels every pair
    curReq = "R4";
    for (int i = 0; i < 256; i++) step(1, 1, 0, 8'hFF);
    chk("R4 all-ones result", eccReg, 32'd0);
    chk("R4 all-ones done", {31'd0, chunkDone}, 32'd1);

    // R5: byte equals its index, back to back
    curReq = "R5";
    for (int i = 0; i < 256; i++) step(1, 1, 0, 8'(i));
    chk("R5 index pattern done", {31'd0, chunkDone}, 32'd1);
    step(0, 1, 0, 8'd0);
    step(0, 1, 0, 8'd0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule